// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt sources into one request line for a processor. Each source is fixed at elaboration time as edge-sensitive or level-sensitive. Captured requests are held in a status register. A per-source enable register masks them into a pending set. The lowest-numbered pending source is reported as a vector number that software reads to choose its handler.

Software reaches the controller through a simple 32-bit word bus. It has eight word registers. Status, pending, enable, acknowledge, set-enable, clear-enable, vector and master sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C. The two-bit master register has two separate gates. Bit 1 lets hardware capture requests into status. Bit 0 lets the pending set drive the request line. While hardware capture is off, software may write status directly to raise requests for test.

Top module: `vec_intc`

## Requirements
- R1: After reset the status, enable and master registers and the stored input history are zero, `irq_out` is low, and `bus_rdata` is zero.
- R2: While master bit 1 is set, a level-sensitive source (sensitivity bit 0) that is high sets its status bit on every clock. Acknowledging the bit while the source stays high leaves it set.
- R3: While master bit 1 is set, a 0-to-1 change of an edge-sensitive source (sensitivity bit 1) between two clock samples sets its status bit. A source that only stays high does not set it again. A rise that happens while master bit 1 is clear is never captured, even after the bit is later set.
- R4: A read at 0x04 returns the status register ANDed with the enable register.
- R5: A read at 0x18 returns the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R6: `irq_out` is a register that, after each clock, is high exactly when master bit 0 and at least one pending bit are set in the state that clock produced.
- R7: A write at 0x0C clears every status bit written as 1. A capture on the same bit in the same cycle wins, so that bit stays set.
- R8: A write at 0x10 ORs the data into the enable register. A write at 0x14 clears every enable bit written as 1. A write at 0x08 replaces the enable register.
- R9: A write at 0x1C stores only data bits 1:0 into the master register. Reads at 0x1C return them zero-extended.
- R10: A write at 0x00 replaces the status register only while master bit 1 is clear. Otherwise the write has no effect.
- R11: Reads at 0x0C, 0x10 and 0x14 return zero. Writes at 0x04 and 0x18 change no state.
- R12: `bus_rdata` is loaded on the clock edge of a read cycle with the register value from before that edge. It holds its value through cycles that are not reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 32 | Interrupt source lines, synchronous to `clk` |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
Directed cases hold a level source high through an acknowledge, which separates a level capture from an edge capture. They also hold an edge source high through an acknowledge and raise an edge source while capture is disabled. These two cases show whether the input history is sampled independently of the gate. The same-cycle acknowledge and edge case separates "capture wins" from "acknowledge wins". Software writes to status with capture off and on check the lock. A long random phase toggles a few sources per cycle and interleaves bus operations at every offset. It is compared every cycle against a bench model, which exercises vector priority among many pending bits.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [2:0] {
    RG_STAT   = 3'd0,
    RG_PEND   = 3'd1,
    RG_ENAB   = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VEC    = 3'd6,
    RG_MASTER = 3'd7
  } vic_reg_e;

  typedef struct packed {
    logic stat;
    logic enab;
    logic ack;
    logic seten;
    logic clren;
    logic master;
  } vic_wr_t;

endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int N = 32,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic         hw_en,
  output logic [N-1:0] hit
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= src;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      assign hit[i] = hw_en & src[i] & ~prev_q[i];
    end else begin : g_level
      assign hit[i] = hw_en & src[i];
    end
  end

endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  vic_wr_t      wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] hit,
  output logic [N-1:0] status_q,
  output logic [N-1:0] enable_q,
  output logic [1:0]   master_q,
  output logic [N-1:0] status_d,
  output logic [N-1:0] enable_d,
  output logic [1:0]   master_d
);

  always_comb begin
    status_d = status_q;
    if (wr.stat && !master_q[1]) status_d = wdata;
    if (wr.ack)                  status_d = status_d & ~wdata;
    status_d = status_d | hit;
  end

  always_comb begin
    enable_d = enable_q;
    if (wr.enab)  enable_d = wdata;
    if (wr.seten) enable_d = enable_q | wdata;
    if (wr.clren) enable_d = enable_q & ~wdata;
  end

  assign master_d = wr.master ? wdata[1:0] : master_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      master_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      master_q <= master_d;
    end
  end

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end

  assign any = |pend;

endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 32'hFFFF_0000,
  localparam int LANE_W = $clog2(DATA_W / 8),
  localparam int ADDR_W = LANE_W + 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic              irq_out
);

  vic_reg_e     word;
  logic         aligned;
  logic         do_wr;
  logic         do_rd;
  vic_wr_t      wr;

  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] status_q, enable_q, status_d, enable_d;
  logic [1:0]         master_q, master_d;
  logic [NUM_SRC-1:0] pend_q;
  logic [IDX_W-1:0]   vec_idx;
  logic               vec_any;
  logic [DATA_W-1:0]  rd_mux;

  assign word    = vic_reg_e'(bus_addr[ADDR_W-1:LANE_W]);
  assign aligned = (bus_addr[LANE_W-1:0] == '0);
  assign do_wr   = bus_en &  bus_we & aligned;
  assign do_rd   = bus_en & ~bus_we & aligned;

  always_comb begin
    wr        = '0;
    wr.stat   = do_wr && (word == RG_STAT);
    wr.enab   = do_wr && (word == RG_ENAB);
    wr.ack    = do_wr && (word == RG_ACK);
    wr.seten  = do_wr && (word == RG_SETEN);
    wr.clren  = do_wr && (word == RG_CLREN);
    wr.master = do_wr && (word == RG_MASTER);
  end

  vic_capture #(.N(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk   (clk),
    .rst   (rst),
    .src   (irq_src),
    .hw_en (master_q[1]),
    .hit   (hit)
  );

  vic_regs #(.N(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr),
    .wdata    (bus_wdata[NUM_SRC-1:0]),
    .hit      (hit),
    .status_q (status_q),
    .enable_q (enable_q),
    .master_q (master_q),
    .status_d (status_d),
    .enable_d (enable_d),
    .master_d (master_d)
  );

  assign pend_q = status_q & enable_q;

  vic_prio #(.N(NUM_SRC)) u_prio (
    .pend (pend_q),
    .idx  (vec_idx),
    .any  (vec_any)
  );

  always_comb begin
    rd_mux = '0;
    unique case (word)
      RG_STAT:   rd_mux[NUM_SRC-1:0] = status_q;
      RG_PEND:   rd_mux[NUM_SRC-1:0] = pend_q;
      RG_ENAB:   rd_mux[NUM_SRC-1:0] = enable_q;
      RG_VEC: begin
        if (vec_any) rd_mux[IDX_W-1:0] = vec_idx;
        else         rd_mux = '1;
      end
      RG_MASTER: rd_mux[1:0] = master_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (do_rd) bus_rdata <= rd_mux;
      irq_out <= master_d[0] & (|(status_d & enable_d));
    end
  end

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int N      = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_out,
  input logic [N-1:0]      status_q,
  input logic [N-1:0]      enable_q,
  input logic [1:0]        master_q
);

  logic [2:0] w;
  logic       wok;
  assign w   = bus_addr[ADDR_W-1:ADDR_W-3];
  assign wok = bus_en && bus_we && (bus_addr[ADDR_W-4:0] == '0);

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> master_q[0]); // R6

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (|(status_q & enable_q))); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wok && w == 3'd3 && !master_q[1]) |=> ((status_q & $past(bus_wdata[N-1:0])) == '0)); // R7

  AST_STAT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (master_q[1] && !(wok && w == 3'd3)) |=> ((status_q & $past(status_q)) == $past(status_q))); // R10

  AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!master_q[1] && !(wok && w == 3'd0)) |=> ((status_q & ~$past(status_q)) == '0)); // R3

  AST_SETEN_SETS: assert property (@(posedge clk) disable iff (rst)
    (wok && w == 3'd4) |=> ((enable_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0]))); // R8

  AST_CLREN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wok && w == 3'd5) |=> ((enable_q & $past(bus_wdata[N-1:0])) == '0)); // R8

endmodule

bind vec_intc vec_intc_chk #(.N(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_out   (irq_out),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .master_q  (master_q)
);

// File: tb/vec_intc_bench.sv
`timescale 1ns/1ps
module vec_intc_bench;

  localparam logic [31:0] EDGE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_src = '0;
  logic        irq_out;

  always #2.5 clk = ~clk;

  vec_intc #(.NUM_SRC(32), .DATA_W(32), .EDGE_MASK(EDGE)) u_vec_intc (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_out(irq_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_isr = '0, m_ier = '0, m_prev = '0, src_v = '0;
  logic [1:0]  m_mer = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lowest(logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mread(logic [2:0] w);
    case (w)
      3'd0: return m_isr;
      3'd1: return m_isr & m_ier;
      3'd2: return m_ier;
      3'd6: return lowest(m_isr & m_ier);
      3'd7: return {30'd0, m_mer};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] w);
    case (w)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R8";
      3'd6: return "R5";
      3'd7: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic cyc(logic en, logic we, logic [2:0] w, logic [31:0] d);
    logic [31:0] exp_rd, hit, nisr, nier;
    logic [1:0]  nmer;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = {w, 2'b00}; bus_wdata = d; irq_src = src_v;
    @(posedge clk);
    exp_rd = mread(w);
    hit  = m_mer[1] ? ((src_v & ~EDGE) | (src_v & EDGE & ~m_prev)) : 32'd0;
    nisr = m_isr; nier = m_ier; nmer = m_mer;
    if (en && we) begin
      case (w)
        3'd0: if (!m_mer[1]) nisr = d;
        3'd2: nier = d;
        3'd3: nisr = nisr & ~d;
        3'd4: nier = nier | d;
        3'd5: nier = nier & ~d;
        3'd7: nmer = d[1:0];
        default: ;
      endcase
    end
    m_isr = nisr | hit; m_ier = nier; m_mer = nmer; m_prev = src_v;
    #1;
    if (en && !we) chk(tag_of(w), bus_rdata, exp_rd);
    chk("R6", {31'd0, irq_out}, {31'd0, m_mer[0] && ((m_isr & m_ier) != 0)});
  endtask

  task automatic wr(logic [2:0] w, logic [31:0] d); cyc(1, 1, w, d); endtask
  task automatic rd(logic [2:0] w); cyc(1, 0, w, 32'd0); endtask
  task automatic idle(); cyc(0, 0, 3'd0, 32'd0); endtask
  task automatic rdx(logic [2:0] w, logic [31:0] exp, string tag);
    rd(w); chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", {31'd0, irq_out}, 32'd0);
    chk("R1", bus_rdata, 32'd0);
    for (int w = 0; w < 8; w++) begin
      if (w == 6) rdx(3'(w), 32'hFFFF_FFFF, "R1");
      else        rdx(3'(w), 32'd0, "R1");
    end

    // R2 level capture persists through acknowledge
    wr(3'd7, 32'd3); wr(3'd2, 32'hFFFF_FFFF);
    src_v = 32'h8; idle();
    rdx(3'd0, 32'h8, "R2");
    wr(3'd3, 32'h8);
    rdx(3'd0, 32'h8, "R2");
    rdx(3'd6, 32'd3, "R5");
    chk("R6", {31'd0, irq_out}, 32'd1);
    src_v = 0; wr(3'd3, 32'h8);
    rdx(3'd0, 32'h0, "R7");
    rdx(3'd6, 32'hFFFF_FFFF, "R5");

    // R3 edge source held high is captured once
    src_v = 32'h0010_0000; idle();
    rdx(3'd0, 32'h0010_0000, "R3");
    wr(3'd3, 32'h0010_0000); idle();
    rdx(3'd0, 32'h0, "R3");
    src_v = 0; idle();

    // R6 output gate, R4 pending, R8 enable ops, R9 master width
    wr(3'd7, 32'd2); src_v = 32'h2; idle();
    chk("R6", {31'd0, irq_out}, 32'd0);
    rdx(3'd1, 32'h2, "R4");
    wr(3'd5, 32'h2);
    rdx(3'd1, 32'h0, "R4");
    rdx(3'd2, 32'hFFFF_FFFD, "R8");
    wr(3'd4, 32'h2);
    rdx(3'd2, 32'hFFFF_FFFF, "R8");
    wr(3'd7, 32'hFFFF_FFFF);
    rdx(3'd7, 32'd3, "R9");
    chk("R6", {31'd0, irq_out}, 32'd1);

    // R3 rise while capture disabled is lost
    src_v = 0; wr(3'd3, 32'hFFFF_FFFF); wr(3'd7, 32'd0);
    src_v = 32'h0020_0000; idle();
    wr(3'd7, 32'd3); idle();
    rdx(3'd0, 32'h0, "R3");

    // R10 software status write lock
    src_v = 0; wr(3'd7, 32'd0); wr(3'd0, 32'h5);
    rdx(3'd0, 32'h5, "R10");
    wr(3'd7, 32'd2); wr(3'd0, 32'h0);
    rdx(3'd0, 32'h5, "R10");

    // R7 acknowledge and new edge in the same cycle
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd7, 32'd3);
    src_v = 32'h0040_0000; idle();
    src_v = 0; idle();
    src_v = 32'h0040_0000; wr(3'd3, 32'h0040_0000);
    rdx(3'd0, 32'h0040_0000, "R7");
    src_v = 0; wr(3'd3, 32'h0040_0000);
    rdx(3'd0, 32'h0, "R7");

    // R11 write-only and derived registers
    wr(3'd7, 32'd0); wr(3'd0, 32'h30); wr(3'd2, 32'h0000_F0F0);
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd6, 32'h0);
    rdx(3'd2, 32'h0000_F0F0, "R8");
    rdx(3'd3, 32'h0, "R11");
    rdx(3'd4, 32'h0, "R11");
    rdx(3'd5, 32'h0, "R11");
    rdx(3'd1, 32'h30, "R11");
    rdx(3'd6, 32'd4, "R11");

    // R12 read data holds without reads
    wr(3'd2, 32'h0); idle();
    chk("R12", bus_rdata, 32'd4);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [2:0] w;
      logic [31:0] d;
      src_v = src_v ^ ($urandom & $urandom & $urandom);
      op = $urandom_range(0, 9);
      w  = 3'($urandom_range(0, 7));
      d  = $urandom;
      if (w == 3'd7 && $urandom_range(0, 3) != 0) d = 32'd3;
      if (op < 3)      idle();
      else if (op < 6) rd(w);
      else             wr(w, d);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule